// File: doc/BRIEF.md
# TDM Auxiliary Slot Extractor

This block takes in a 16-slot time-division multiplexed audio frame and splits it three ways. Each slot is 32 bits wide. The first four slots carry nothing and are dropped. The next eight slots are delivered one word at a time to an internal sample interface, tagged with a channel number. The last four slots are held and sent out again on two stereo serial outputs in I2S format. Each output carries one left/right pair.

The block runs on a single system clock. Each TDM bit arrives as a one-cycle strobe, `tdm_bit_en`, together with its data bit. A frame sync flag marks the first bit of slot 1. The auxiliary bit clock and left/right clock are derived from the position inside the TDM frame: each auxiliary bit lasts eight TDM bits, and each auxiliary half-frame lasts 256 TDM bits. The four auxiliary words captured in one frame are sent during the following frame. They are double buffered, so a frame that is still arriving cannot corrupt the pair being sent.

Top module: `tdm_aux_extractor`

## Requirements
- R1: After reset, all outputs are 0 and `loc_valid` stays low until a frame has begun.
- R2: Bits strobed before the first frame sync have no effect: no local word appears, and the auxiliary clocks and data stay 0.
- R3: A bit strobed with `tdm_fsync` high is bit 0 of the frame, which is the MSB of slot 1. Every slot is 32 bits, MSB first.
- R4: Slots 1 to 4 never produce a local word.
- R5: Slots 5 to 12 each produce one `loc_valid` pulse in the clock after their last bit's strobe. `loc_chan` runs 0 to 7 in slot order (L1, R1, L2, R2, L3, R3, L4, R4), and `loc_word` holds the slot's 32 bits.
- R6: Slots 13 and 14 become the left and right words of `aux_sdata[0]`. Slots 15 and 16 become the left and right words of `aux_sdata[1]`.
- R7: `aux_bclk` is 1 for TDM bits 4 to 7 of each group of eight and 0 otherwise. `aux_lrclk` is 0 (left) for frame bits 0 to 255 and 1 (right) for bits 256 to 511. Both change only on a strobed bit.
- R8: The aux data is I2S. Each auxiliary bit starts on a multiple of eight TDM bits. The left MSB is sent in auxiliary bit 1, and the right MSB in auxiliary bit 33. The right LSB is sent in auxiliary bit 0 of the next frame.
- R9: Words captured in frame N are sent in frame N+1. Capturing frame N+1 does not disturb them.
- R10: The aux outputs send zeros until one complete frame, ending with the last bit of slot 16, has been received.
- R11: A frame sync that arrives early restarts the count at bit 0. An incomplete frame never replaces the auxiliary words being sent.
- R12: Without a new frame sync, the bit count wraps from 511 to 0 and frames continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdm_bit_en | input | 1 | Strobe: one TDM bit is present this cycle |
| tdm_fsync | input | 1 | Frame start, qualified by `tdm_bit_en` |
| tdm_sdata | input | 1 | TDM serial data bit |
| loc_valid | output | 1 | Local word valid (one cycle) |
| loc_chan | output | 3 | Local channel number, 0 to 7 |
| loc_word | output | 32 | Local channel sample |
| aux_bclk | output | 1 | Auxiliary bit clock |
| aux_lrclk | output | 1 | Auxiliary left/right clock, 0 = left |
| aux_sdata | output | 2 | Auxiliary I2S data, one bit per output |

## Verification
Every result of this block is registered once behind the strobe that causes it. A local word, a clock level or an aux data bit is therefore due in the clock edge that follows the `tdm_bit_en` cycle, and then holds until the next strobe. The bench drives each strobe on a falling edge and updates a behavioural model with it. It compares every output at the next falling edge, which is exactly one rising edge later. Each auxiliary word reaches the output one frame after it was captured, and the model covers that delay with its own per-output bit queues, which are refilled at auxiliary bit 1.

// File: rtl/tdm_aux_pkg.sv
package tdm_aux_pkg;
  localparam int SLOT_W       = 32;
  localparam int NUM_SLOTS    = 16;
  localparam int SKIP_SLOTS   = 4;
  localparam int NUM_LOCAL    = 8;
  localparam int NUM_AUX_OUT  = 2;

  localparam int FRAME_BITS   = NUM_SLOTS * SLOT_W;
  localparam int CNT_W        = $clog2(FRAME_BITS);
  localparam int BIT_IDX_W    = $clog2(SLOT_W);
  localparam int SLOT_IDX_W   = $clog2(NUM_SLOTS);
  localparam int CHAN_W       = $clog2(NUM_LOCAL);
  localparam int AUX_SLOTS    = 2 * NUM_AUX_OUT;
  localparam int FIRST_AUX    = SKIP_SLOTS + NUM_LOCAL;
  localparam int AUX_FRAME_W  = 2 * SLOT_W;
  localparam int AUX_DIV      = FRAME_BITS / AUX_FRAME_W;
  localparam int AUX_DIV_W    = $clog2(AUX_DIV);

  typedef logic [SLOT_W-1:0] word_t;
  typedef logic [CNT_W-1:0]  pos_t;
endpackage

// File: rtl/tdm_frame_counter.sv
module tdm_frame_counter
  import tdm_aux_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic fsync,
  output logic live,
  output pos_t pos
);
  pos_t cnt_q, cnt_d;
  logic synced_q, synced_d;

  always_comb begin
    live     = bit_en && (synced_q || fsync);
    cnt_d    = cnt_q;
    synced_d = synced_q;
    if (live) begin
      synced_d = 1'b1;
      if (fsync || cnt_q == CNT_W'(FRAME_BITS - 1)) cnt_d = '0;
      else                                          cnt_d = cnt_q + CNT_W'(1);
    end
    pos = cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      synced_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      synced_q <= synced_d;
    end
  end

  // R12
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (synced_q && bit_en && !fsync && cnt_q != CNT_W'(FRAME_BITS - 1))
      |=> cnt_q == $past(cnt_q) + CNT_W'(1));

  // R3
  fsync_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && fsync) |=> (cnt_q == '0 && synced_q));
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tdm_aux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  live,
  input  pos_t  pos,
  input  logic  sdata,
  output logic  loc_valid,
  output logic [CHAN_W-1:0] loc_chan,
  output word_t loc_word,
  output logic  have_frame,
  output word_t play [AUX_SLOTS]
);
  word_t shift_q, shift_d;
  logic  slot_done;
  logic [SLOT_IDX_W-1:0] slot;
  logic  is_local, is_last;
  logic  lv_q, lv_d;
  logic [CHAN_W-1:0] ch_q, ch_d;
  word_t wd_q, wd_d;
  logic  have_q, have_d;
  word_t cap_q [AUX_SLOTS];
  word_t play_q [AUX_SLOTS];

  always_comb begin
    shift_d   = live ? {shift_q[SLOT_W-2:0], sdata} : shift_q;
    slot      = pos[CNT_W-1:BIT_IDX_W];
    slot_done = live && (pos[BIT_IDX_W-1:0] == BIT_IDX_W'(SLOT_W - 1));
    is_local  = (slot >= SLOT_IDX_W'(SKIP_SLOTS)) && (slot < SLOT_IDX_W'(FIRST_AUX));
    is_last   = (slot == SLOT_IDX_W'(NUM_SLOTS - 1));
    lv_d      = slot_done && is_local;
    ch_d      = lv_d ? CHAN_W'(slot - SLOT_IDX_W'(SKIP_SLOTS)) : ch_q;
    wd_d      = lv_d ? shift_d : wd_q;
    have_d    = have_q || (slot_done && is_last);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      lv_q    <= 1'b0;
      ch_q    <= '0;
      wd_q    <= '0;
      have_q  <= 1'b0;
    end else begin
      shift_q <= shift_d;
      lv_q    <= lv_d;
      ch_q    <= ch_d;
      wd_q    <= wd_d;
      have_q  <= have_d;
    end
  end

  for (genvar i = 0; i < AUX_SLOTS; i++) begin : g_aux_slot
    word_t cap_d, play_d;
    logic  hit;
    always_comb begin
      hit    = slot_done && (slot == SLOT_IDX_W'(FIRST_AUX + i));
      cap_d  = hit ? shift_d : cap_q[i];
      play_d = play_q[i];
      if (slot_done && is_last) play_d = (i == AUX_SLOTS - 1) ? shift_d : cap_q[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cap_q[i]  <= '0;
        play_q[i] <= '0;
      end else begin
        cap_q[i]  <= cap_d;
        play_q[i] <= play_d;
      end
    end
    assign play[i] = play_q[i];
  end

  assign loc_valid  = lv_q;
  assign loc_chan   = ch_q;
  assign loc_word   = wd_q;
  assign have_frame = have_q;

  // R5
  loc_after_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid |-> $past(live));

  // R10
  have_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    have_frame |=> have_frame);

  // R9
  play_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(slot_done && is_last) |-> $stable(play_q[0]));
endmodule

// File: rtl/aux_i2s_serializer.sv
module aux_i2s_serializer
  import tdm_aux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  live,
  input  pos_t  pos,
  input  logic  have_frame,
  input  word_t left_w,
  input  word_t right_w,
  output logic  sdata
);
  logic [AUX_FRAME_W-1:0] sh_q, sh_d;
  logic load, grp_start;

  always_comb begin
    load      = live && (pos == CNT_W'(AUX_DIV));
    grp_start = live && (pos[AUX_DIV_W-1:0] == '0);
    sh_d      = sh_q;
    if (load)           sh_d = have_frame ? {left_w, right_w} : '0;
    else if (grp_start) sh_d = {sh_q[AUX_FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sdata = sh_q[AUX_FRAME_W-1];

  // R10
  zero_before_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have_frame |-> !sdata);

  // R8
  data_moves_on_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sdata != $past(sdata)) |-> $past(grp_start));
endmodule

// File: rtl/tdm_aux_extractor.sv
module tdm_aux_extractor
  import tdm_aux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tdm_bit_en,
  input  logic              tdm_fsync,
  input  logic              tdm_sdata,
  output logic              loc_valid,
  output logic [CHAN_W-1:0] loc_chan,
  output logic [SLOT_W-1:0] loc_word,
  output logic              aux_bclk,
  output logic              aux_lrclk,
  output logic [NUM_AUX_OUT-1:0] aux_sdata
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       live;
  pos_t       pos;
  logic       have_frame;
  word_t      play [AUX_SLOTS];
  logic       bclk_q, bclk_d, lr_q, lr_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tdm_frame_counter u_cnt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .bit_en (tdm_bit_en),
    .fsync  (tdm_fsync),
    .live   (live),
    .pos    (pos)
  );

  tdm_slot_router u_route (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .live       (live),
    .pos        (pos),
    .sdata      (tdm_sdata),
    .loc_valid  (loc_valid),
    .loc_chan   (loc_chan),
    .loc_word   (loc_word),
    .have_frame (have_frame),
    .play       (play)
  );

  for (genvar o = 0; o < NUM_AUX_OUT; o++) begin : g_aux_out
    aux_i2s_serializer u_ser (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .live       (live),
      .pos        (pos),
      .have_frame (have_frame),
      .left_w     (play[2*o]),
      .right_w    (play[2*o+1]),
      .sdata      (aux_sdata[o])
    );
  end

  always_comb begin
    bclk_d = live ? pos[AUX_DIV_W-1] : bclk_q;
    lr_d   = live ? pos[CNT_W-1]     : lr_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      bclk_q <= 1'b0;
      lr_q   <= 1'b0;
    end else begin
      bclk_q <= bclk_d;
      lr_q   <= lr_d;
    end
  end

  assign aux_bclk  = bclk_q;
  assign aux_lrclk = lr_q;

  // R7
  bclk_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aux_bclk != $past(aux_bclk)) |-> $past(live));

  // R7
  lrclk_on_bit_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (aux_lrclk != $past(aux_lrclk)) |-> $past(live));
endmodule

// File: tb/tb_tdm_aux_extractor.sv
module tb_tdm_aux_extractor;
  logic        clk;
  logic        rst_n;
  logic        bit_en, fsync, sdin;
  logic        loc_valid;
  logic [2:0]  loc_chan;
  logic [31:0] loc_word;
  logic        aux_bclk, aux_lrclk;
  logic [1:0]  aux_sdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  tdm_aux_extractor dut (
    .clk(clk), .rst_n(rst_n), .tdm_bit_en(bit_en), .tdm_fsync(fsync),
    .tdm_sdata(sdin), .loc_valid(loc_valid), .loc_chan(loc_chan),
    .loc_word(loc_word), .aux_bclk(aux_bclk), .aux_lrclk(aux_lrclk),
    .aux_sdata(aux_sdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural model state
  bit          m_sync = 0;
  int          m_idx = 0;
  logic [31:0] m_word = 0;
  logic [31:0] m_cap [4];
  logic [31:0] m_ready [4];
  bit          m_have = 0;
  bit          m_loaded = 0;
  bit          q0[$];
  bit          q1[$];
  logic        e_bclk = 0, e_lr = 0, e_valid = 0;
  logic [2:0]  e_chan = 0;
  logic [31:0] e_word = 0;
  int          e_slot = 0;
  string       ph = "R1";

  task automatic chk1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chkw(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    string areq;
    areq = m_loaded ? ph : "R10";
    chk1("R7", "aux_bclk", aux_bclk, e_bclk);
    chk1("R7", "aux_lrclk", aux_lrclk, e_lr);
    chk1({areq, "/R6/R8"}, "aux_sdata0", aux_sdata[0], (q0.size() > 0) ? q0[0] : 1'b0);
    chk1({areq, "/R6/R8"}, "aux_sdata1", aux_sdata[1], (q1.size() > 0) ? q1[0] : 1'b0);
    if (!m_sync) chk1("R2", "loc_valid", loc_valid, e_valid);
    else if (e_slot < 4) chk1("R4", "loc_valid", loc_valid, e_valid);
    else chk1("R5", "loc_valid", loc_valid, e_valid);
    if (e_valid && loc_valid) begin
      chkw("R5", "loc_chan", {29'd0, loc_chan}, {29'd0, e_chan});
      chkw("R3/R5", "loc_word", loc_word, e_word);
    end
  endtask

  task automatic model_bit(logic fs, logic d);
    int slot;
    e_valid = 0;
    if (!m_sync && !fs) return;
    m_sync = 1;
    m_idx  = fs ? 0 : (m_idx + 1) % 512;
    m_word = {m_word[30:0], d};
    e_slot = m_idx / 32;
    if (m_idx % 32 == 31) begin
      slot = m_idx / 32;
      if (slot >= 4 && slot < 12) begin
        e_valid = 1;
        e_chan  = 3'(slot - 4);
        e_word  = m_word;
      end
      if (slot >= 12) m_cap[slot-12] = m_word;
      if (slot == 15) begin
        m_have = 1;
        for (int k = 0; k < 4; k++) m_ready[k] = m_cap[k];
      end
    end
    e_bclk = ((m_idx / 4) % 2) == 1;
    e_lr   = m_idx >= 256;
    if (m_idx == 8) begin
      q0.delete();
      q1.delete();
      if (m_have) begin
        m_loaded = 1;
        for (int b = 31; b >= 0; b--) q0.push_back(m_ready[0][b]);
        for (int b = 31; b >= 0; b--) q0.push_back(m_ready[1][b]);
        for (int b = 31; b >= 0; b--) q1.push_back(m_ready[2][b]);
        for (int b = 31; b >= 0; b--) q1.push_back(m_ready[3][b]);
      end
    end else if (m_idx % 8 == 0) begin
      if (q0.size() > 0) void'(q0.pop_front());
      if (q1.size() > 0) void'(q1.pop_front());
    end
  endtask

  task automatic cyc(logic en, logic fs, logic d);
    @(negedge clk);
    compare();
    bit_en = en;
    fsync  = fs;
    sdin   = d;
    if (en) model_bit(fs, d);
    else    e_valid = 0;
  endtask

  function automatic logic [31:0] wfn(int fr, int slot);
    return {8'(fr), 4'h0, 4'(slot), ~8'(fr), 4'(slot) ^ 4'hA, 4'h5};
  endfunction

  task automatic send_frame(int fr, bit use_fs, int nbits);
    logic [31:0] w;
    for (int b = 0; b < nbits; b++) begin
      w = wfn(fr, b / 32);
      cyc(1'b1, use_fs && (b == 0), w[31 - (b % 32)]);
      cyc(1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin
      m_cap[k] = 0;
      m_ready[k] = 0;
    end
    rst_n = 0; bit_en = 0; fsync = 0; sdin = 0;
    repeat (3) @(negedge clk);
    // R1: outputs idle in reset
    compare();
    rst_n = 1;
    for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b0);
    // R2: strobes before any frame sync
    ph = "R2";
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 1'b0, 1'(i % 3 == 0));
      cyc(1'b0, 1'b0, 1'b0);
    end
    ph = "R8";
    send_frame(1, 1, 512);
    send_frame(2, 1, 512);
    ph = "R9";
    send_frame(3, 1, 512);
    // R11: early frame sync inside slot 15
    ph = "R11";
    send_frame(4, 1, 458);
    send_frame(5, 1, 512);
    // R12: no frame sync, counter wraps
    ph = "R12";
    send_frame(6, 0, 512);
    ph = "R9";
    send_frame(7, 1, 512);
    send_frame(8, 1, 100);
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule